// File: doc/BRIEF.md
# Bus-Master Thermal Sensor Sampling Sequencer

This block runs the sampling side of an on-chip thermal monitor that has no converter of its own. At a programmed interval it takes a shared auxiliary ADC through a simple memory-mapped bus master. It then visits up to four sensing points, one after another. For each enabled point it routes the analog sensor mux to that point, deselects and re-enables the ADC channel, and polls a status word until a configured valid flag shows. The conversion value it reads is shifted, cut to 12 bits and held in a result register for that point.

Every address and data word the sequencer puts on the bus comes from a configuration register. The same hardware can therefore drive any converter that signals completion with a flag bit in a readable word. The valid flag is located by a bit position and a polarity, and the voltage can come from the status word or from a second read. Software programs the block through a word-indexed register port and reads the results back through it.

Top module: `sensorPollSeq`

## Requirements
- R1: After reset `busReq` is low, every result reads 0, the timeout register reads all ones and the other configuration registers read 0.
- R2: A round starts every `unit*256*interval` clocks, where `unit` is bits 9:0 of register 0 and `interval` is bits 9:0 of register 1. Either value at 0 stops rounds.
- R3: A round visits the points whose bit is set in register 4 (bit n means point n), in ascending order. A point whose bit is clear produces no bus traffic.
- R4: For each point the transactions come in this order: a write of the point's 5-bit mux value (registers 16..19) to the sensor-mux address (register 9), a write of the channel word (register 11) to the channel-clear address (register 10), a write of the enable word (register 13) to the enable address (register 12), then a read of the status address (register 14).
- R5: Register 5 bit 0 gates the sensor-mux write and bit 1 gates the channel-clear write. A gated write is skipped with no bus request, and the enable write and the poll still happen.
- R6: The valid flag is status bit `p`, where `p` is register 6 bits 4:0. When register 6 bit 5 is 1 the flag means valid when 1, otherwise it means valid when 0.
- R7: After a poll that is not valid, at least `pollIv` (register 2) idle cycles plus two pass before the next poll request.
- R8: With register 3 = T and T not all ones, a point is abandoned after T polls that are not valid. Its result is unchanged and the round moves on. When T is all ones, polling continues until the flag is valid.
- R9: When register 8 bit 0 is 0 the valid status word also supplies the voltage. When it is 1, a read of the voltage address (register 15) follows and supplies the voltage.
- R10: The result (registers 20..23, read-only) is bits 11:0 of the voltage word shifted right by register 7 bits 3:0. It changes only when a valid read completes.
- R11: While `busReq` is high and `busReady` is low, `busAddr`, `busWe` and `busWdata` hold steady. A transaction completes on the edge where both are high.
- R12: Register 1 holds the filter interval in bits 25:16 next to the sampling interval, and it reads back what was written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cfgWe | input | 1 | Configuration write strobe |
| cfgAddr | input | 5 | Configuration word index |
| cfgWdata | input | 32 | Configuration write data |
| cfgRdata | output | 32 | Configuration read data for `cfgAddr` |
| busReq | output | 1 | Bus master transaction request |
| busWe | output | 1 | 1 for a write, 0 for a read |
| busAddr | output | 32 | Transaction address |
| busWdata | output | 32 | Write data |
| busRdata | input | 32 | Read data, sampled in the ready cycle |
| busReady | input | 1 | Slave completes the current transaction |

## Verification
The assertions assume the slave raises `busReady` only while `busReq` is high and presents read data in that same cycle. They also assume the configuration stays fixed while a round is in flight, apart from the sampling interval. The bench's slave model answers after a fixed wait and never raises ready unprompted. Each scenario sets the configuration while the interval is 0, then opens the interval just long enough to launch one round, so no round overlaps a reconfiguration.

// File: rtl/sensorPollPkg.sv
package sensorPollPkg;
  localparam int NPTS       = 4;
  localparam int ADDR_W     = 32;
  localparam int DATA_W     = 32;
  localparam int RES_W      = 12;
  localparam int PER_W      = 10;
  localparam int UNIT_SHIFT = 8;
  localparam int IV_W       = 16;
  localparam int SHIFT_W    = 4;
  localparam int MUX_W      = 5;
  localparam int REG_AW     = 5;
  localparam int PT_W       = $clog2(NPTS);
  localparam int CNT_W      = PER_W + UNIT_SHIFT;
  localparam int FILT_LSB   = 16;
  localparam int POS_W      = $clog2(DATA_W);

  localparam logic [REG_AW-1:0] RA_UNIT   = 5'd0;
  localparam logic [REG_AW-1:0] RA_TIMING = 5'd1;
  localparam logic [REG_AW-1:0] RA_POLLIV = 5'd2;
  localparam logic [REG_AW-1:0] RA_TMO    = 5'd3;
  localparam logic [REG_AW-1:0] RA_MASK   = 5'd4;
  localparam logic [REG_AW-1:0] RA_WCTL   = 5'd5;
  localparam logic [REG_AW-1:0] RA_VCFG   = 5'd6;
  localparam logic [REG_AW-1:0] RA_SHIFT  = 5'd7;
  localparam logic [REG_AW-1:0] RA_SPLIT  = 5'd8;
  localparam logic [REG_AW-1:0] RA_SNSA   = 5'd9;
  localparam logic [REG_AW-1:0] RA_CLRA   = 5'd10;
  localparam logic [REG_AW-1:0] RA_CHW    = 5'd11;
  localparam logic [REG_AW-1:0] RA_ENA    = 5'd12;
  localparam logic [REG_AW-1:0] RA_ENW    = 5'd13;
  localparam logic [REG_AW-1:0] RA_VALA   = 5'd14;
  localparam logic [REG_AW-1:0] RA_VOLTA  = 5'd15;
  localparam logic [REG_AW-1:0] RA_PTMUX  = 5'd16;
  localparam logic [REG_AW-1:0] RA_RES    = 5'd20;

  typedef enum logic [2:0] {
    ST_IDLE, ST_SEL, ST_SNS, ST_CLR, ST_EN, ST_POLL, ST_WAIT, ST_VOLT
  } seqState_t;

  typedef enum logic [2:0] {
    BK_SNS, BK_CLR, BK_EN, BK_VAL, BK_VOLT
  } busKind_t;

  typedef struct packed {
    logic            issue;
    busKind_t        kind;
    logic            storeRes;
    logic [PT_W-1:0] ptIdx;
  } ctrlStrb_t;

  typedef struct packed {
    logic              roundStart;
    logic [NPTS-1:0]   mask;
    logic              wcSns;
    logic              wcChan;
    logic              rdSplit;
    logic [IV_W-1:0]   pollIv;
    logic [DATA_W-1:0] tmo;
    logic              validHit;
  } pathStat_t;
endpackage

// File: rtl/sensorPollPath.sv
module sensorPollPath
  import sensorPollPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWe,
  input  logic [REG_AW-1:0] cfgAddr,
  input  logic [DATA_W-1:0] cfgWdata,
  output logic [DATA_W-1:0] cfgRdata,
  input  ctrlStrb_t         strb,
  output pathStat_t         stat,
  input  logic              busReq,
  input  logic              busReady,
  input  logic [DATA_W-1:0] busRdata,
  output logic              busWe,
  output logic [ADDR_W-1:0] busAddr,
  output logic [DATA_W-1:0] busWdata
);
  logic [PER_W-1:0]   unitQ, sensIvQ, filtIvQ;
  logic [IV_W-1:0]    pollIvQ;
  logic [DATA_W-1:0]  tmoQ;
  logic [NPTS-1:0]    maskQ;
  logic [1:0]         wcQ;
  logic [5:0]         vcfgQ;
  logic [SHIFT_W-1:0] shiftQ;
  logic               splitQ;
  logic [ADDR_W-1:0]  snsAddrQ, clrAddrQ, enAddrQ, valAddrQ, voltAddrQ;
  logic [DATA_W-1:0]  chanWordQ, enWordQ;
  logic [MUX_W-1:0]   ptMuxQ [NPTS];
  logic [RES_W-1:0]   resQ [NPTS];

  // configuration registers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      unitQ <= '0; sensIvQ <= '0; filtIvQ <= '0; pollIvQ <= '0;
      tmoQ <= '1; maskQ <= '0; wcQ <= '0; vcfgQ <= '0; shiftQ <= '0;
      splitQ <= 1'b0; snsAddrQ <= '0; clrAddrQ <= '0; enAddrQ <= '0;
      valAddrQ <= '0; voltAddrQ <= '0; chanWordQ <= '0; enWordQ <= '0;
    end else if (cfgWe) begin
      case (cfgAddr)
        RA_UNIT:   unitQ <= cfgWdata[PER_W-1:0];
        RA_TIMING: begin
          sensIvQ <= cfgWdata[PER_W-1:0];
          filtIvQ <= cfgWdata[FILT_LSB +: PER_W];
        end
        RA_POLLIV: pollIvQ   <= cfgWdata[IV_W-1:0];
        RA_TMO:    tmoQ      <= cfgWdata;
        RA_MASK:   maskQ     <= cfgWdata[NPTS-1:0];
        RA_WCTL:   wcQ       <= cfgWdata[1:0];
        RA_VCFG:   vcfgQ     <= cfgWdata[5:0];
        RA_SHIFT:  shiftQ    <= cfgWdata[SHIFT_W-1:0];
        RA_SPLIT:  splitQ    <= cfgWdata[0];
        RA_SNSA:   snsAddrQ  <= cfgWdata;
        RA_CLRA:   clrAddrQ  <= cfgWdata;
        RA_CHW:    chanWordQ <= cfgWdata;
        RA_ENA:    enAddrQ   <= cfgWdata;
        RA_ENW:    enWordQ   <= cfgWdata;
        RA_VALA:   valAddrQ  <= cfgWdata;
        RA_VOLTA:  voltAddrQ <= cfgWdata;
        default: ;
      endcase
    end
  end

  // valid flag decode and voltage extraction
  logic             flagBit, validHit;
  logic [RES_W-1:0] voltVal;
  assign flagBit  = busRdata[vcfgQ[POS_W-1:0]];
  assign validHit = vcfgQ[5] ? flagBit : ~flagBit;
  assign voltVal  = RES_W'(busRdata >> shiftQ);

  // per-point mux values and results
  for (genvar g = 0; g < NPTS; g++) begin : gPt
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) ptMuxQ[g] <= '0;
      else if (cfgWe && cfgAddr == RA_PTMUX + REG_AW'(g)) ptMuxQ[g] <= cfgWdata[MUX_W-1:0];
    end
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) resQ[g] <= '0;
      else if (strb.storeRes && strb.ptIdx == PT_W'(g)) resQ[g] <= voltVal;
    end
    // R10
    result_src_chk: assert property (@(posedge clk) disable iff (!rstN)
      !$stable(resQ[g]) |-> $past(busReq && busReady && !busWe));
  end

  // interval timer: unit tick every unitQ*256 clocks, round every sensIvQ ticks
  logic [CNT_W-1:0] preCnt, unitLim;
  logic [PER_W-1:0] ivCnt;
  logic             unitTick, roundStart;
  assign unitLim    = CNT_W'(unitQ) << UNIT_SHIFT;
  assign unitTick   = (unitQ != '0) && (preCnt >= unitLim - 1'b1);
  assign roundStart = unitTick && (sensIvQ != '0) && (ivCnt >= sensIvQ - 1'b1);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      preCnt <= '0;
      ivCnt  <= '0;
    end else begin
      preCnt <= (unitQ == '0 || unitTick) ? '0 : preCnt + 1'b1;
      if (sensIvQ == '0)   ivCnt <= '0;
      else if (roundStart) ivCnt <= '0;
      else if (unitTick)   ivCnt <= ivCnt + 1'b1;
    end
  end

  // R2
  round_gap_chk: assert property (@(posedge clk) disable iff (!rstN)
    roundStart |=> !roundStart);

  // bus request latch: held until the next issue
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busWe <= 1'b0; busAddr <= '0; busWdata <= '0;
    end else if (strb.issue) begin
      case (strb.kind)
        BK_SNS:  begin busWe <= 1'b1; busAddr <= snsAddrQ; busWdata <= DATA_W'(ptMuxQ[strb.ptIdx]); end
        BK_CLR:  begin busWe <= 1'b1; busAddr <= clrAddrQ; busWdata <= chanWordQ; end
        BK_EN:   begin busWe <= 1'b1; busAddr <= enAddrQ;  busWdata <= enWordQ; end
        BK_VAL:  begin busWe <= 1'b0; busAddr <= valAddrQ; busWdata <= '0; end
        default: begin busWe <= 1'b0; busAddr <= voltAddrQ; busWdata <= '0; end
      endcase
    end
  end

  // status toward the control
  always_comb begin
    stat.roundStart = roundStart;
    stat.mask       = maskQ;
    stat.wcSns      = wcQ[0];
    stat.wcChan     = wcQ[1];
    stat.rdSplit    = splitQ;
    stat.pollIv     = pollIvQ;
    stat.tmo        = tmoQ;
    stat.validHit   = validHit;
  end

  // register read mux
  always_comb begin
    cfgRdata = '0;
    case (cfgAddr)
      RA_UNIT:   cfgRdata[PER_W-1:0] = unitQ;
      RA_TIMING: begin
        cfgRdata[PER_W-1:0]         = sensIvQ;
        cfgRdata[FILT_LSB +: PER_W] = filtIvQ;
      end
      RA_POLLIV: cfgRdata[IV_W-1:0]    = pollIvQ;
      RA_TMO:    cfgRdata              = tmoQ;
      RA_MASK:   cfgRdata[NPTS-1:0]    = maskQ;
      RA_WCTL:   cfgRdata[1:0]         = wcQ;
      RA_VCFG:   cfgRdata[5:0]         = vcfgQ;
      RA_SHIFT:  cfgRdata[SHIFT_W-1:0] = shiftQ;
      RA_SPLIT:  cfgRdata[0]           = splitQ;
      RA_SNSA:   cfgRdata = snsAddrQ;
      RA_CLRA:   cfgRdata = clrAddrQ;
      RA_CHW:    cfgRdata = chanWordQ;
      RA_ENA:    cfgRdata = enAddrQ;
      RA_ENW:    cfgRdata = enWordQ;
      RA_VALA:   cfgRdata = valAddrQ;
      RA_VOLTA:  cfgRdata = voltAddrQ;
      default: ;
    endcase
    for (int i = 0; i < NPTS; i++) begin
      if (cfgAddr == RA_PTMUX + REG_AW'(i)) cfgRdata = DATA_W'(ptMuxQ[i]);
      if (cfgAddr == RA_RES + REG_AW'(i))   cfgRdata = DATA_W'(resQ[i]);
    end
  end
endmodule

// File: rtl/sensorPollCtrl.sv
module sensorPollCtrl
  import sensorPollPkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  pathStat_t stat,
  input  logic      busReady,
  output logic      busReq,
  output ctrlStrb_t strb
);
  seqState_t         state;
  logic              reqQ;
  logic [PT_W-1:0]   ptIdx;
  logic [PT_W:0]     scanFrom;
  logic [NPTS-1:0]   roundMask;
  logic [DATA_W-1:0] pollCnt;
  logic [IV_W-1:0]   waitCnt;

  logic      isBus, need, done, tmoExpire, found;
  logic [PT_W-1:0] pick;
  seqState_t nextBus;

  assign busReq = reqQ;
  assign done   = reqQ && busReady;
  assign isBus  = (state == ST_SNS) || (state == ST_CLR) || (state == ST_EN) ||
                  (state == ST_POLL) || (state == ST_VOLT);
  assign tmoExpire = (stat.tmo != '1) &&
                     ((stat.tmo == '0) || (pollCnt >= stat.tmo - 1'b1));

  // next enabled point at or above scanFrom
  always_comb begin
    found = 1'b0;
    pick  = '0;
    for (int i = NPTS - 1; i >= 0; i--) begin
      if (roundMask[i] && ((PT_W+1)'(i) >= scanFrom)) begin
        found = 1'b1;
        pick  = PT_W'(i);
      end
    end
  end

  always_comb begin
    need = 1'b1;
    if (state == ST_SNS) need = stat.wcSns;
    if (state == ST_CLR) need = stat.wcChan;
    case (state)
      ST_SNS:  nextBus = ST_CLR;
      ST_CLR:  nextBus = ST_EN;
      ST_EN:   nextBus = ST_POLL;
      ST_POLL: begin
        if (stat.validHit) nextBus = stat.rdSplit ? ST_VOLT : ST_SEL;
        else               nextBus = tmoExpire ? ST_SEL : ST_WAIT;
      end
      default: nextBus = ST_SEL;
    endcase
    strb.issue    = isBus && need && !reqQ;
    strb.ptIdx    = ptIdx;
    strb.storeRes = done && (((state == ST_POLL) && stat.validHit && !stat.rdSplit) ||
                             (state == ST_VOLT));
    case (state)
      ST_SNS:  strb.kind = BK_SNS;
      ST_CLR:  strb.kind = BK_CLR;
      ST_EN:   strb.kind = BK_EN;
      ST_POLL: strb.kind = BK_VAL;
      default: strb.kind = BK_VOLT;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE; reqQ <= 1'b0; ptIdx <= '0; scanFrom <= '0;
      roundMask <= '0; pollCnt <= '0; waitCnt <= '0;
    end else begin
      case (state)
        ST_IDLE: if (stat.roundStart) begin
          roundMask <= stat.mask;
          scanFrom  <= '0;
          state     <= ST_SEL;
        end
        ST_SEL: begin
          if (found) begin
            ptIdx    <= pick;
            scanFrom <= {1'b0, pick} + 1'b1;
            pollCnt  <= '0;
            state    <= ST_SNS;
          end else begin
            state <= ST_IDLE;
          end
        end
        ST_WAIT: begin
          if (waitCnt >= stat.pollIv) state <= ST_POLL;
          else                        waitCnt <= waitCnt + 1'b1;
        end
        default: begin
          if (!need) begin
            state <= nextBus;
          end else if (!reqQ) begin
            reqQ <= 1'b1;
          end else if (busReady) begin
            reqQ  <= 1'b0;
            state <= nextBus;
            if (state == ST_POLL) begin
              pollCnt <= pollCnt + 1'b1;
              waitCnt <= '0;
            end
          end
        end
      endcase
    end
  end

  // R3
  mask_only_chk: assert property (@(posedge clk) disable iff (!rstN)
    reqQ |-> roundMask[ptIdx]);

  // R8
  tmo_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_WAIT) |-> ((stat.tmo == '1) || (pollCnt < stat.tmo)));

  // R4
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE) |-> !reqQ);
endmodule

// File: rtl/sensorPollSeq.sv
module sensorPollSeq
  import sensorPollPkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        cfgWe,
  input  logic [4:0]  cfgAddr,
  input  logic [31:0] cfgWdata,
  output logic [31:0] cfgRdata,
  output logic        busReq,
  output logic        busWe,
  output logic [31:0] busAddr,
  output logic [31:0] busWdata,
  input  logic [31:0] busRdata,
  input  logic        busReady
);
  ctrlStrb_t strb;
  pathStat_t stat;

  sensorPollCtrl u_ctrl (
    .clk(clk), .rstN(rstN), .stat(stat), .busReady(busReady),
    .busReq(busReq), .strb(strb)
  );

  sensorPollPath u_path (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgAddr(cfgAddr),
    .cfgWdata(cfgWdata), .cfgRdata(cfgRdata), .strb(strb), .stat(stat),
    .busReq(busReq), .busReady(busReady), .busRdata(busRdata),
    .busWe(busWe), .busAddr(busAddr), .busWdata(busWdata)
  );

  // R11
  bus_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busReq && !busReady) |=> (busReq && $stable(busAddr) && $stable(busWe) && $stable(busWdata)));
endmodule

// File: tb/sensorPollSeq_bench.sv
module sensorPollSeq_bench;
  localparam logic [4:0] A_UNIT = 0, A_TIM = 1, A_PIV = 2, A_TMO = 3, A_MASK = 4,
    A_WCTL = 5, A_VCFG = 6, A_SHIFT = 7, A_SPLIT = 8, A_SNSA = 9, A_CLRA = 10,
    A_CHW = 11, A_ENA = 12, A_ENW = 13, A_VALA = 14, A_VOLTA = 15, A_MUX = 16, A_RES = 20;
  localparam logic [31:0] SNS = 32'h1000_0604, CLR = 32'h2000_000C, ENA = 32'h2000_0008,
    VALA = 32'h2000_0040, VOLTA = 32'h2000_0044, CHW = 32'h0000_0800, ENW = 32'h0000_1800;
  localparam int LAT = 2;

  logic clk = 1'b0, rstN = 1'b0, cfgWe = 1'b0, busReady = 1'b0;
  logic [4:0] cfgAddr = '0;
  logic [31:0] cfgWdata = '0, busRdata = '0, cfgRdata, busAddr, busWdata;
  logic busReq, busWe;

  sensorPollSeq u_sensorPollSeq (.*);

  always #2 clk = ~clk;

  int cyc = 0, checks = 0, errors = 0;
  always @(posedge clk) cyc <= cyc + 1;

  logic [31:0] logAddr [64], logData [64];
  logic        logWe [64];
  int          logCyc [64];
  int logN = 0, pollSeen = 0, validAfter = 0, rspWait = 0;
  logic [31:0] respValid = '0, respInvalid = '0, respVolt = '0, holdAddr, holdData;

  task automatic chkEq(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // bus slave model
  initial forever begin
    @(negedge clk);
    if (busReady) begin
      busReady = 1'b0;
      rspWait  = 0;
    end else if (busReq) begin
      if (rspWait == 0) begin
        holdAddr = busAddr; holdData = busWdata;
      end else begin
        chkEq("R11 addr hold", busAddr, holdAddr);
        chkEq("R11 data hold", busWdata, holdData);
      end
      if (rspWait < LAT) rspWait++;
      else begin
        if (logN < 64) begin
          logAddr[logN] = busAddr; logData[logN] = busWdata;
          logWe[logN] = busWe; logCyc[logN] = cyc;
          logN++;
        end
        busRdata = '0;
        if (!busWe && busAddr == VALA) begin
          pollSeen++;
          busRdata = (pollSeen > validAfter) ? respValid : respInvalid;
        end else if (!busWe && busAddr == VOLTA) busRdata = respVolt;
        busReady = 1'b1;
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog actual=%0d expected=done", cyc);
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  task automatic cfgWr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk); cfgWe = 1'b1; cfgAddr = a; cfgWdata = d;
    @(negedge clk); cfgWe = 1'b0;
  endtask

  task automatic cfgRd(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk); cfgAddr = a; #1; d = cfgRdata;
  endtask

  task automatic chkTx(input int i, input logic we, input logic [31:0] a,
                       input logic [31:0] d, input string req);
    chkEq({req, " we"}, 32'(logWe[i]), 32'(we));
    chkEq({req, " addr"}, logAddr[i], a);
    if (we) chkEq({req, " data"}, logData[i], d);
  endtask

  task automatic runRound();
    logN = 0; pollSeen = 0;
    cfgWr(A_UNIT, 1);
    cfgWr(A_TIM, 1);
    for (int k = 0; k < 2000 && logN == 0; k++) @(negedge clk);
    cfgWr(A_TIM, 0);
    repeat (400) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    chkEq("R1 busReq", 32'(busReq), 0);
    cfgRd(A_TMO, d);  chkEq("R1 timeout reset", d, 32'hFFFF_FFFF);
    cfgRd(A_VCFG, d); chkEq("R1 vcfg reset", d, 0);
    for (int i = 0; i < 4; i++) begin
      cfgRd(A_RES + 5'(i), d); chkEq("R1 result reset", d, 0);
    end
  endtask

  task automatic t_readback();
    logic [31:0] d;
    cfgWr(A_TIM, 32'h0001_01AD | 32'hFC00_FC00);
    cfgRd(A_TIM, d); chkEq("R12 timing readback", d, 32'h0001_01AD);
    cfgWr(A_TIM, 0);
    cfgWr(A_RES, 32'h0000_0FFF);
    cfgRd(A_RES, d); chkEq("R10 result read-only", d, 0);
  endtask

  task automatic t_sequence();
    logic [31:0] d;
    logic [31:0] mv [4] = '{0, 1, 3, 16};
    int pts [3] = '{0, 1, 3};
    cfgWr(A_SNSA, SNS); cfgWr(A_CLRA, CLR); cfgWr(A_CHW, CHW);
    cfgWr(A_ENA, ENA); cfgWr(A_ENW, ENW); cfgWr(A_VALA, VALA); cfgWr(A_VOLTA, VOLTA);
    for (int i = 0; i < 4; i++) cfgWr(A_MUX + 5'(i), mv[i]);
    cfgWr(A_MASK, 4'b1011); cfgWr(A_WCTL, 3); cfgWr(A_VCFG, 32'h20 | 12);
    cfgWr(A_SHIFT, 0); cfgWr(A_SPLIT, 0);
    respValid = 32'h0000_1ABC; respInvalid = 0; validAfter = 0;
    runRound();
    chkEq("R3 transaction count", logN, 12);
    for (int k = 0; k < 3; k++) begin
      chkTx(4*k,   1, SNS, mv[pts[k]], "R4 sensor mux write");
      chkTx(4*k+1, 1, CLR, CHW, "R4 channel clear write");
      chkTx(4*k+2, 1, ENA, ENW, "R4 enable write");
      chkTx(4*k+3, 0, VALA, 0, "R4 status poll");
    end
    cfgRd(A_RES + 0, d); chkEq("R10 result p0", d, 32'hABC);
    cfgRd(A_RES + 1, d); chkEq("R10 result p1", d, 32'hABC);
    cfgRd(A_RES + 2, d); chkEq("R3 disabled p2 untouched", d, 0);
    cfgRd(A_RES + 3, d); chkEq("R6 result p3", d, 32'hABC);
  endtask

  task automatic t_wctl();
    cfgWr(A_MASK, 1);
    cfgWr(A_WCTL, 0); runRound();
    chkEq("R5 none count", logN, 2);
    chkTx(0, 1, ENA, ENW, "R5 none enable");
    chkTx(1, 0, VALA, 0, "R5 none poll");
    cfgWr(A_WCTL, 1); runRound();
    chkEq("R5 sns-only count", logN, 3);
    chkTx(0, 1, SNS, 0, "R5 sns-only mux");
    chkTx(1, 1, ENA, ENW, "R5 sns-only enable");
    cfgWr(A_WCTL, 2); runRound();
    chkEq("R5 chan-only count", logN, 3);
    chkTx(0, 1, CLR, CHW, "R5 chan-only clear");
    chkTx(1, 1, ENA, ENW, "R5 chan-only enable");
  endtask

  task automatic t_polarity();
    logic [31:0] d;
    cfgWr(A_WCTL, 0); cfgWr(A_VCFG, 3); cfgWr(A_SHIFT, 4); cfgWr(A_PIV, 6);
    respValid = 32'h0000_5670; respInvalid = 32'h0000_0008; validAfter = 2;
    runRound();
    chkEq("R6 poll count active low", pollSeen, 3);
    cfgRd(A_RES, d); chkEq("R6 R10 shifted result", d, 32'h567);
    chkEq("R7 poll gap a", 32'((logCyc[2] - logCyc[1]) >= 8), 1);
    chkEq("R7 poll gap b", 32'((logCyc[3] - logCyc[2]) >= 8), 1);
  endtask

  task automatic t_timeout();
    logic [31:0] d;
    cfgWr(A_TMO, 3); validAfter = 100;
    runRound();
    chkEq("R8 polls before abandon", pollSeen, 3);
    chkEq("R8 abandoned count", logN, 4);
    cfgRd(A_RES, d); chkEq("R8 result kept", d, 32'h567);
    cfgWr(A_TMO, 32'hFFFF_FFFF); cfgWr(A_PIV, 2);
    respValid = 32'h0000_9A40; validAfter = 5;
    runRound();
    chkEq("R8 no-timeout polls", pollSeen, 6);
    cfgRd(A_RES, d); chkEq("R8 no-timeout result", d, 32'h9A4);
  endtask

  task automatic t_split();
    logic [31:0] d;
    cfgWr(A_VCFG, 32'h20 | 12); cfgWr(A_SHIFT, 0); cfgWr(A_SPLIT, 1);
    respValid = 32'h0000_1FFF; respVolt = 32'h0000_0123; validAfter = 0;
    runRound();
    chkEq("R9 split count", logN, 3);
    chkTx(2, 0, VOLTA, 0, "R9 voltage read");
    cfgRd(A_RES, d); chkEq("R9 split result", d, 32'h123);
    cfgWr(A_SPLIT, 0);
  endtask

  task automatic t_timing();
    logN = 0; pollSeen = 0;
    cfgWr(A_UNIT, 1); cfgWr(A_TIM, 3);
    for (int k = 0; k < 5000 && logN < 6; k++) @(negedge clk);
    cfgWr(A_TIM, 0);
    chkEq("R2 period 768 a", logCyc[2] - logCyc[0], 768);
    chkEq("R2 period 768 b", logCyc[4] - logCyc[2], 768);
    repeat (400) @(negedge clk);
    logN = 0;
    cfgWr(A_UNIT, 2); cfgWr(A_TIM, 1);
    for (int k = 0; k < 5000 && logN < 4; k++) @(negedge clk);
    cfgWr(A_TIM, 0);
    chkEq("R2 period 512", logCyc[2] - logCyc[0], 512);
    repeat (400) @(negedge clk);
    logN = 0;
    repeat (2000) @(negedge clk);
    chkEq("R2 interval zero idle", logN, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    t_reset();
    t_readback();
    t_sequence();
    t_wctl();
    t_polarity();
    t_timeout();
    t_split();
    t_timing();
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule